// File: doc/BRIEF.md
# Parity-Framed Serial Command Message Transmitter

This block turns one command into a run of 8-bit link bytes on a byte-wide serial link. The command is a crate address, a station number, a subaddress and a function code, plus an optional 24-bit write word. Each link byte holds six payload bits, one delimiter bit and one parity bit, and the parity bit makes the count of ones in the byte odd. A free-running slot timer sets the byte rate. Every slot the block presents one byte together with a one-cycle strobe. When no message is in flight, the slot carries a wait byte.

The message is sent in a fixed order: the four header bytes, then the data bytes if the function is a write, then a sum byte. The sum byte carries even column parity over the payload columns of the message bytes. After it come the space bytes that give the remote controller time to answer, and then an end byte. There are two ways to set the number of space bytes:
- **Counted mode:** the count is programmed per command, up to sixteen.
- **Extended mode:** space bytes keep coming until a stop input reports that a reply has arrived or that the command has been cut short.

A done pulse marks the end byte, and the link then goes back to wait bytes.

Top module: `cmd_msg_tx`

## Requirements
- R1: Every byte on `tx_byte` has payload in bits [5:0], delimiter in bit 6 and, in bit 7, a parity bit that makes the total number of ones in the 8-bit byte odd.
- R2: While idle, one wait byte is presented per slot: delimiter 1 and payload `WAIT_CODE` (0x00 by default, giving 0x40). `byte_stb` is high for exactly one cycle every `BYTE_DIV` cycles (4 by default).
- R3: A message starts with four header bytes, each with delimiter 0, in this order:
  - crate address in payload [5:0];
  - station number in payload [4:0], with payload bit 5 = 1;
  - subaddress in payload [3:0], with payload bits [5:4] = 00;
  - function code in payload [4:0], with payload bit 5 = 1.
- R4: A write function (function[4:3] = 2'b10) is followed by four data bytes with delimiter 0, carrying write data [23:18], [17:12], [11:6] and [5:0] in that order.
- R5: Any other function code sends no data bytes, so the sum byte directly follows the function byte.
- R6: The sum byte has delimiter 0, and its payload is the bitwise XOR of the payloads of all preceding bytes of the message.
- R7: In counted mode the sum byte is followed by min(`space_len`, 16) space bytes, then one end byte. A space byte has delimiter 1 and payload `SPACE_CODE` (0x2A). The end byte has delimiter 1 and payload `END_CODE` (0x15).
- R8: In extended mode, space bytes follow the sum byte until `space_stop` has been seen at any time after the start was accepted, and then the end byte is sent. If the stop was seen before the sum byte, no space bytes are sent.
- R9: `tx_done` is high for one cycle, in the same cycle as the strobe of the end byte. `busy` falls in that same cycle, and the next slot carries a wait byte.
- R10: `start` is accepted only while `busy` is low, and all command inputs are sampled in that cycle. A `start` while `busy` is high is ignored, and input changes after acceptance have no effect on the message.
- R11: During and right after reset, `tx_byte` is the wait byte and `byte_stb`, `busy` and `tx_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send the presented command |
| crate | input | 6 | Crate address |
| station | input | 5 | Station number |
| subaddr | input | 4 | Subaddress |
| func | input | 5 | Function code |
| wdata | input | 24 | Write data |
| space_len | input | 5 | Space byte count for counted mode (values above 16 act as 16) |
| ext_space | input | 1 | Selects extended mode |
| space_stop | input | 1 | Reply seen or command terminated; ends extended spacing |
| tx_byte | output | 8 | Current link byte |
| byte_stb | output | 1 | One-cycle strobe marking a new link byte |
| busy | output | 1 | A message is in flight |
| tx_done | output | 1 | One-cycle pulse with the end byte |

## Verification
The hardest case to reach is extended spacing, because its length depends on when `space_stop` arrives relative to the slot grid. The bench counts space bytes as they appear on the link and raises the stop only after six have been seen. It then checks that the run ended within two slots of the stop and that the end byte came right after it. A second extended command raises the stop during the header to cover the case with no spaces. A separate test fires `start` and changes the command inputs in the middle of a message, to show that neither touches the bytes already in flight.

// File: rtl/msg_tx_pkg.sv
`timescale 1ns/1ps
package msg_tx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_STN, S_SUB, S_FUN, S_DATA, S_SUM, S_SPACE, S_END
  } seq_st_t;

  typedef enum logic [2:0] {
    K_WAIT, K_MSG, K_SUM, K_SPACE, K_END
  } byte_kind_t;

  // Build a link byte: {odd parity, delimiter, payload}
  function automatic logic [7:0] frame_byte(input logic [5:0] pl, input logic dl);
    return {~(^{dl, pl}), dl, pl};
  endfunction

  // Write functions occupy codes 16..23
  function automatic logic is_write_fn(input logic [4:0] fn);
    return fn[4] & ~fn[3];
  endfunction

endpackage

// File: rtl/msg_slot_timer.sv
`timescale 1ns/1ps
module msg_slot_timer #(
  parameter int BYTE_DIV = 4,
  localparam int CW = (BYTE_DIV > 1) ? $clog2(BYTE_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [CW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= CW'(BYTE_DIV - 1);
    else           cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/msg_tx_seq.sv
`timescale 1ns/1ps
module msg_tx_seq import msg_tx_pkg::*; #(
  parameter int DATA_BYTES = 4,
  parameter int MAX_SPACE  = 16,
  localparam int DW   = 6 * DATA_BYTES,
  localparam int SL_W = $clog2(MAX_SPACE + 1),
  localparam int DI_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            start,
  input  logic [5:0]      crate,
  input  logic [4:0]      station,
  input  logic [3:0]      subaddr,
  input  logic [4:0]      func,
  input  logic [DW-1:0]   wdata,
  input  logic [SL_W-1:0] space_len,
  input  logic            ext_space,
  input  logic            space_stop,
  output byte_kind_t      kind,
  output logic [5:0]      payload,
  output logic            busy
);
  seq_st_t         st;
  logic [5:0]      crate_r;
  logic [4:0]      stn_r;
  logic [3:0]      sub_r;
  logic [4:0]      fn_r;
  logic [DW-1:0]   data_sh;
  logic [DI_W-1:0] didx;
  logic [SL_W-1:0] spc_left;
  logic            ext_r;
  logic            stop_l;
  logic            stop_any;
  logic            halt_sum;
  logic            halt_sp;

  assign stop_any = stop_l | space_stop;
  assign halt_sum = ext_r ? stop_any : (spc_left == '0);
  assign halt_sp  = ext_r ? stop_any : (spc_left == SL_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      busy     <= 1'b0;
      stop_l   <= 1'b0;
      ext_r    <= 1'b0;
      crate_r  <= '0;
      stn_r    <= '0;
      sub_r    <= '0;
      fn_r     <= '0;
      data_sh  <= '0;
      didx     <= '0;
      spc_left <= '0;
    end else begin
      if (busy && space_stop) stop_l <= 1'b1;
      if (!busy && start) begin
        crate_r  <= crate;
        stn_r    <= station;
        sub_r    <= subaddr;
        fn_r     <= func;
        data_sh  <= wdata;
        ext_r    <= ext_space;
        stop_l   <= 1'b0;
        busy     <= 1'b1;
        spc_left <= (space_len > SL_W'(MAX_SPACE)) ? SL_W'(MAX_SPACE) : space_len;
      end
      if (tick && busy) begin
        case (st)
          S_IDLE: st <= S_STN;
          S_STN:  st <= S_SUB;
          S_SUB:  st <= S_FUN;
          S_FUN: begin
            didx <= '0;
            st   <= is_write_fn(fn_r) ? S_DATA : S_SUM;
          end
          S_DATA: begin
            data_sh <= data_sh << 6;
            didx    <= didx + 1'b1;
            if (didx == DI_W'(DATA_BYTES - 1)) st <= S_SUM;
          end
          S_SUM: st <= halt_sum ? S_END : S_SPACE;
          S_SPACE: begin
            if (!ext_r) spc_left <= spc_left - 1'b1;
            if (halt_sp) st <= S_END;
          end
          S_END: begin
            st   <= S_IDLE;
            busy <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    kind    = K_WAIT;
    payload = '0;
    case (st)
      S_IDLE: if (busy) begin kind = K_MSG; payload = crate_r; end
      S_STN:   begin kind = K_MSG; payload = {1'b1, stn_r};   end
      S_SUB:   begin kind = K_MSG; payload = {2'b00, sub_r};  end
      S_FUN:   begin kind = K_MSG; payload = {1'b1, fn_r};    end
      S_DATA:  begin kind = K_MSG; payload = data_sh[DW-1 -: 6]; end
      S_SUM:   kind = K_SUM;
      S_SPACE: kind = K_SPACE;
      S_END:   kind = K_END;
      default: kind = K_WAIT;
    endcase
  end
endmodule

// File: rtl/msg_byte_former.sv
`timescale 1ns/1ps
module msg_byte_former import msg_tx_pkg::*; #(
  parameter logic [5:0] WAIT_CODE  = 6'h00,
  parameter logic [5:0] SPACE_CODE = 6'h2A,
  parameter logic [5:0] END_CODE   = 6'h15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  byte_kind_t kind,
  input  logic [5:0] payload,
  output logic [7:0] tx_byte,
  output logic       byte_stb,
  output logic       tx_done
);
  logic [5:0] col_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte  <= frame_byte(WAIT_CODE, 1'b1);
      byte_stb <= 1'b0;
      tx_done  <= 1'b0;
      col_sum  <= '0;
    end else begin
      byte_stb <= tick;
      tx_done  <= tick && (kind == K_END);
      if (tick) begin
        case (kind)
          K_MSG: begin
            tx_byte <= frame_byte(payload, 1'b0);
            col_sum <= col_sum ^ payload;
          end
          K_SUM: begin
            tx_byte <= frame_byte(col_sum, 1'b0);
            col_sum <= '0;
          end
          K_SPACE: tx_byte <= frame_byte(SPACE_CODE, 1'b1);
          K_END:   tx_byte <= frame_byte(END_CODE, 1'b1);
          default: tx_byte <= frame_byte(WAIT_CODE, 1'b1);
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_msg_tx.sv
`timescale 1ns/1ps
module cmd_msg_tx import msg_tx_pkg::*; #(
  parameter int         BYTE_DIV   = 4,
  parameter int         DATA_BYTES = 4,
  parameter int         MAX_SPACE  = 16,
  parameter logic [5:0] WAIT_CODE  = 6'h00,
  parameter logic [5:0] SPACE_CODE = 6'h2A,
  parameter logic [5:0] END_CODE   = 6'h15,
  localparam int DW   = 6 * DATA_BYTES,
  localparam int SL_W = $clog2(MAX_SPACE + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [5:0]      crate,
  input  logic [4:0]      station,
  input  logic [3:0]      subaddr,
  input  logic [4:0]      func,
  input  logic [DW-1:0]   wdata,
  input  logic [SL_W-1:0] space_len,
  input  logic            ext_space,
  input  logic            space_stop,
  output logic [7:0]      tx_byte,
  output logic            byte_stb,
  output logic            busy,
  output logic            tx_done
);
  logic       tick;
  byte_kind_t kind;
  logic [5:0] payload;

  msg_slot_timer #(.BYTE_DIV(BYTE_DIV)) u_timer (
    .clk(clk), .rst(rst), .tick(tick)
  );

  msg_tx_seq #(.DATA_BYTES(DATA_BYTES), .MAX_SPACE(MAX_SPACE)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .crate(crate), .station(station), .subaddr(subaddr), .func(func),
    .wdata(wdata), .space_len(space_len), .ext_space(ext_space),
    .space_stop(space_stop), .kind(kind), .payload(payload), .busy(busy)
  );

  msg_byte_former #(
    .WAIT_CODE(WAIT_CODE), .SPACE_CODE(SPACE_CODE), .END_CODE(END_CODE)
  ) u_former (
    .clk(clk), .rst(rst), .tick(tick), .kind(kind), .payload(payload),
    .tx_byte(tx_byte), .byte_stb(byte_stb), .tx_done(tx_done)
  );
endmodule

// File: rtl/msg_tx_checker.sv
`timescale 1ns/1ps
module msg_tx_checker #(
  parameter int         BYTE_DIV  = 4,
  parameter logic [5:0] WAIT_CODE = 6'h00,
  parameter logic [5:0] END_CODE  = 6'h15
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] tx_byte,
  input logic       byte_stb,
  input logic       busy,
  input logic       tx_done
);
  localparam logic [7:0] WAIT_B = {~(^{1'b1, WAIT_CODE}), 1'b1, WAIT_CODE};
  localparam logic [7:0] END_B  = {~(^{1'b1, END_CODE}), 1'b1, END_CODE};

  // R1
  a_r1_odd_parity: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> (^tx_byte));

  // R2
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    (BYTE_DIV > 1 && byte_stb) |=> !byte_stb);

  // R2
  a_r2_idle_wait: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && !busy && !tx_done) |-> (tx_byte == WAIT_B));

  // R9
  a_r9_done_on_end: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (byte_stb && tx_byte == END_B));

  // R9
  a_r9_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> tx_done);
endmodule

bind cmd_msg_tx msg_tx_checker #(
  .BYTE_DIV(BYTE_DIV), .WAIT_CODE(WAIT_CODE), .END_CODE(END_CODE)
) u_chk (
  .clk(clk), .rst(rst), .tx_byte(tx_byte), .byte_stb(byte_stb),
  .busy(busy), .tx_done(tx_done)
);

// File: tb/cmd_msg_tx_bench.sv
`timescale 1ns/1ps
module cmd_msg_tx_bench;
  localparam logic [5:0] WC = 6'h00;
  localparam logic [5:0] SC = 6'h2A;
  localparam logic [5:0] EC = 6'h15;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0, ext_space = 1'b0, space_stop = 1'b0;
  logic [5:0]  crate = '0;
  logic [4:0]  station = '0, func = '0, space_len = '0;
  logic [3:0]  subaddr = '0;
  logic [23:0] wdata = '0;
  logic [7:0]  tx_byte;
  logic        byte_stb, busy, tx_done;

  cmd_msg_tx u_cmd_msg_tx (
    .clk(clk), .rst(rst), .start(start), .crate(crate), .station(station),
    .subaddr(subaddr), .func(func), .wdata(wdata), .space_len(space_len),
    .ext_space(ext_space), .space_stop(space_stop), .tx_byte(tx_byte),
    .byte_stb(byte_stb), .busy(busy), .tx_done(tx_done)
  );

  function automatic logic [7:0] ob(input logic [5:0] p, input logic d);
    return {~(^{d, p}), d, p};
  endfunction

  int n_cmp = 0, n_bad = 0;
  logic [7:0] blog [0:4095];
  int nlog = 0, done_cnt = 0, done_idx = 0, space_total = 0;

  always @(negedge clk) begin
    if (!rst && byte_stb && nlog < 4096) begin
      blog[nlog] = tx_byte;
      if (tx_byte == ob(SC, 1'b1)) space_total++;
      if (tx_done) begin done_idx = nlog; done_cnt++; end
      nlog++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [5:0] c, input logic [4:0] n, input logic [3:0] a,
                       input logic [4:0] f, input logic [23:0] d, input logic [4:0] s,
                       input logic e);
    @(negedge clk);
    crate = c; station = n; subaddr = a; func = f; wdata = d; space_len = s; ext_space = e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  function automatic int first_msg(input int base);
    for (int i = base; i < nlog; i++) if (blog[i][6] == 1'b0) return i;
    return base;
  endfunction

  // {crate6, station5, sub4, func5, data24, spaces5}
  localparam logic [48:0] VEC [6] = '{
    {6'd1,  5'd1,  4'd0,  5'd0,  24'h000000, 5'd2},
    {6'd62, 5'd23, 4'd15, 5'd16, 24'hABCDEF, 5'd3},
    {6'd33, 5'd10, 4'd5,  5'd24, 24'h123456, 5'd0},
    {6'd7,  5'd30, 4'd9,  5'd17, 24'hFFFFFF, 5'd16},
    {6'd0,  5'd0,  4'd0,  5'd9,  24'h000000, 5'd31},
    {6'd45, 5'd2,  4'd3,  5'd23, 24'h000001, 5'd1}
  };

  task automatic run_vec(input logic [48:0] v);
    logic [5:0] c, sm; logic [4:0] n, f, s; logic [3:0] a; logic [23:0] d;
    logic [7:0] ex [0:31]; string rq [0:31];
    int ne, base, d0, i0, ns;
    {c, n, a, f, d, s} = v;
    base = nlog; d0 = done_cnt;
    issue(c, n, a, f, d, s, 1'b0);
    wait_done(d0);
    ne = 0;
    ex[ne] = ob(c, 0);           rq[ne++] = "R3 crate byte";
    ex[ne] = ob({1'b1, n}, 0);   rq[ne++] = "R3 station byte";
    ex[ne] = ob({2'b00, a}, 0);  rq[ne++] = "R3 subaddress byte";
    ex[ne] = ob({1'b1, f}, 0);   rq[ne++] = "R3 function byte";
    sm = c ^ {1'b1, n} ^ {2'b00, a} ^ {1'b1, f};
    if (f[4:3] == 2'b10) begin
      for (int k = 3; k >= 0; k--) begin
        ex[ne] = ob(d[k*6 +: 6], 0); rq[ne++] = "R4 data byte";
        sm = sm ^ d[k*6 +: 6];
      end
    end
    ex[ne] = ob(sm, 0); rq[ne++] = (f[4:3] == 2'b10) ? "R6 sum byte" : "R5 R6 sum after function";
    ns = (s > 16) ? 16 : int'(s);
    for (int k = 0; k < ns; k++) begin ex[ne] = ob(SC, 1); rq[ne++] = "R7 space byte"; end
    ex[ne] = ob(EC, 1); rq[ne++] = "R7 end byte";
    i0 = first_msg(base);
    for (int k = 0; k < ne; k++) begin
      chk(rq[k], 32'(blog[i0+k]), 32'(ex[k]));
      chk("R1 odd parity", 32'(^blog[i0+k]), 32'd1);
    end
    chk("R9 done with end byte index", 32'(done_idx), 32'(i0 + ne - 1));
    while (nlog <= done_idx + 1) @(negedge clk);
    chk("R9 wait byte after end", 32'(blog[done_idx+1]), 32'(ob(WC, 1)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int s0, d0, i0, nsp;
    repeat (4) @(negedge clk);
    chk("R11 byte in reset", 32'(tx_byte), 32'(ob(WC, 1)));
    rst = 1'b0;
    chk("R11 byte after reset", 32'(tx_byte), 32'h40);
    chk("R11 strobe after reset", 32'(byte_stb), 32'd0);
    chk("R11 busy after reset", 32'(busy), 32'd0);
    chk("R11 done after reset", 32'(tx_done), 32'd0);

    // R2: idle strobe rate and wait bytes
    repeat (3) @(negedge clk);
    s0 = nlog;
    repeat (40) @(negedge clk);
    chk("R2 strobes per 40 cycles", 32'(nlog - s0), 32'd10);
    for (int k = s0; k < nlog; k++) chk("R2 idle wait byte", 32'(blog[k]), 32'h40);

    for (int v = 0; v < 6; v++) run_vec(VEC[v]);

    // R10: start while busy ignored, inputs changed after acceptance
    s0 = nlog; d0 = done_cnt;
    issue(6'd5, 5'd4, 4'd2, 5'd0, 24'h0, 5'd1, 1'b0);
    crate = 6'h3F; func = 5'd16;
    repeat (8) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(d0);
    i0 = first_msg(s0);
    chk("R10 crate sampled at start", 32'(blog[i0]), 32'(ob(6'd5, 0)));
    chk("R10 function sampled at start", 32'(blog[i0+3]), 32'(ob({1'b1, 5'd0}, 0)));
    repeat (60) @(negedge clk);
    begin
      int nz = 0;
      for (int k = done_idx + 1; k < nlog; k++) if (blog[k][6] == 1'b0) nz++;
      chk("R10 no second message", 32'(nz), 32'd0);
    end
    chk("R10 idle after ignored start", 32'(busy), 32'd0);

    // R8: extended spacing stopped after six spaces
    s0 = space_total; d0 = done_cnt;
    issue(6'd12, 5'd3, 4'd1, 5'd0, 24'h0, 5'd0, 1'b1);
    while (space_total - s0 < 6) @(negedge clk);
    space_stop = 1'b1; @(negedge clk); space_stop = 1'b0;
    wait_done(d0);
    nsp = space_total - s0;
    chk("R8 extended space count in 6..8", 32'(nsp >= 6 && nsp <= 8), 32'd1);
    chk("R8 end follows spaces", 32'(blog[done_idx]), 32'(ob(EC, 1)));
    chk("R8 space before end", 32'(blog[done_idx-1]), 32'(ob(SC, 1)));

    // R8: stop seen early -> no spaces even with count programmed
    s0 = space_total; d0 = done_cnt;
    issue(6'd20, 5'd8, 4'd6, 5'd1, 24'h0, 5'd5, 1'b1);
    repeat (2) @(negedge clk);
    space_stop = 1'b1; @(negedge clk); space_stop = 1'b0;
    wait_done(d0);
    chk("R8 no spaces after early stop", 32'(space_total - s0), 32'd0);
    chk("R8 sum directly before end", 32'(blog[done_idx-1][6]), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule